// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block runs the memory side of taking and leaving an exception on a small processor core. When an exception is accepted, it captures the eight caller-saved context words from the core. It writes them to a descending stack through a single-word memory port, then moves the stack pointer down and enters handler mode. On entry it also loads the link register with a fixed return code. If the stack pointer is only 4-byte aligned at entry, one unused word is left above the frame so the frame base is always 8-byte aligned. That choice is recorded in bit 9 of the stacked status word.

Return needs no special instruction. While in handler mode, an ordinary branch whose target equals the return code starts the exit. The block reads the frame back from memory and hands the eight words to the core with a one-cycle strobe. It restores the stack pointer, adding back the padding word when the stacked bit 9 asks for it, and drops back to thread mode. A control-register write with bit 26 set makes a timer-tick exception pending, and that pending flag triggers entry just as a hardware request does.

Top module: `exc_stacker`

## Requirements
- R1: On entry the frame occupies eight ascending words starting at the new stack pointer, in the order R0, R1, R2, R3, R12, LR, PC, status word (word index 0 to 7 of `ctx_in`). The stored status word equals the captured one except that bit 9 is 1 when padding was inserted and 0 otherwise.
- R2: The entry lowers the stack pointer by 32 bytes when its bit 2 is 0, or by 36 bytes when bit 2 is 1. The resulting stack pointer is 8-byte aligned.
- R3: With `mem_rdy` always high, `busy` stays high for exactly 12 cycles on entry and 12 cycles on return. Each cycle in which a memory beat sees `mem_rdy` low adds one cycle.
- R4: When entry completes, `handler_mode` becomes 1 and `lr` holds 0xFFFFFFF9.
- R5: A return starts only when `br_valid` is high, `br_target` equals 0xFFFFFFF9, the block is in handler mode and it is not busy. Any other target, or the return code seen in thread mode, leaves mode, stack pointer and `busy` unchanged.
- R6: When return completes, `ctx_restore` pulses for one cycle with `ctx_out` holding the eight popped words, the status word with bit 9 cleared. `handler_mode` returns to 0, and the stack pointer is the frame base plus 32, plus 4 more if the popped bit 9 was 1.
- R7: A `ctl_wr` with bit 26 of `ctl_wdata` set makes `tick_pend` 1. A write with bit 26 clear does nothing. A pending tick causes entry exactly as `irq_req` does, and a further set while pending has no additional effect.
- R8: `tick_pend` clears in the cycle the entry is accepted. Entry is accepted only from thread mode while not busy.
- R9: While `mem_req` is high and `mem_rdy` is low, the next cycle keeps `mem_req` high with the same address and write data.
- R10: After reset `handler_mode`, `busy`, `mem_req`, `tick_pend`, `ctx_restore`, `sp` and `lr` are 0. `sp_wr` loads `sp` from `sp_wdata` only while idle with no entry or return starting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_wr | input | 1 | Load stack pointer |
| sp_wdata | input | 32 | New stack pointer value (word aligned) |
| sp | output | 32 | Current stack pointer |
| irq_req | input | 1 | Level exception request |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data; bit 26 sets tick pending |
| tick_pend | output | 1 | Timer-tick exception pending |
| ctx_in | input | 256 | Context to push, word i at bits 32*i+31:32*i |
| br_valid | input | 1 | Register-indirect branch is executing |
| br_target | input | 32 | Branch target value |
| lr | output | 32 | Link register value set on entry |
| handler_mode | output | 1 | 1 in handler mode, 0 in thread mode |
| busy | output | 1 | Entry or return sequence in progress |
| ctx_out | output | 256 | Popped context, same packing as ctx_in |
| ctx_restore | output | 1 | One-cycle strobe: ctx_out valid |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Beat completes this cycle |

## Verification
A wrong beat counter or base address shows up in the stacked memory image as soon as entry finishes, 12 cycles after acceptance. A lost padding flag stays hidden until return, when the restored stack pointer comes out 4 bytes short. Errors in the tail counter change the `busy` length directly, so the cycle count exposes them in the same sequence. A wrong pending-bit priority shows at the port one cycle after the control write.

// File: rtl/exc_stacker.sv
module exc_stacker #(
  parameter int          ENTRY_CYC = 12,
  parameter int          EXIT_CYC  = 12,
  parameter logic [31:0] RET_CODE  = 32'hFFFF_FFF9,
  parameter int          PEND_BIT  = 26,
  parameter int          PAD_BIT   = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sp_wr,
  input  logic [31:0]  sp_wdata,
  output logic [31:0]  sp,
  input  logic         irq_req,
  input  logic         ctl_wr,
  input  logic [31:0]  ctl_wdata,
  output logic         tick_pend,
  input  logic [255:0] ctx_in,
  input  logic         br_valid,
  input  logic [31:0]  br_target,
  output logic [31:0]  lr,
  output logic         handler_mode,
  output logic         busy,
  output logic [255:0] ctx_out,
  output logic         ctx_restore,
  output logic         mem_req,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic [31:0]  mem_rdata,
  input  logic         mem_rdy
);
  localparam int NW    = 8;
  localparam int ETAIL = ENTRY_CYC - NW;
  localparam int XTAIL = EXIT_CYC - NW;

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_PTAIL, S_POP, S_QTAIL} st_t;

  st_t         st;
  logic [31:0] frame [NW];
  logic [2:0]  beat;
  logic [7:0]  tcnt;
  logic [31:0] base;
  logic        accept, ret_hit, pad;

  assign pad     = sp[2];
  assign accept  = (st == S_IDLE) && !handler_mode && (irq_req || tick_pend);
  assign ret_hit = (st == S_IDLE) && handler_mode && br_valid && (br_target == RET_CODE);

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_PUSH) || (st == S_POP);
  assign mem_we    = (st == S_PUSH);
  assign mem_addr  = base + {27'd0, beat, 2'b00};
  assign mem_wdata = frame[beat];

  always_comb begin
    for (int i = 0; i < NW; i++) ctx_out[32*i +: 32] = frame[i];
    ctx_out[32*(NW-1) + PAD_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      beat         <= '0;
      tcnt         <= '0;
      base         <= '0;
      sp           <= '0;
      lr           <= '0;
      handler_mode <= 1'b0;
      tick_pend    <= 1'b0;
      ctx_restore  <= 1'b0;
      for (int i = 0; i < NW; i++) frame[i] <= '0;
    end else begin
      ctx_restore <= 1'b0;
      if (accept)                             tick_pend <= 1'b0;
      else if (ctl_wr && ctl_wdata[PEND_BIT]) tick_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          if (accept) begin
            for (int i = 0; i < NW; i++) frame[i] <= ctx_in[32*i +: 32];
            frame[NW-1][PAD_BIT] <= pad;
            base <= sp - 32'd32 - (pad ? 32'd4 : 32'd0);
            beat <= '0;
            st   <= S_PUSH;
          end else if (ret_hit) begin
            base <= sp;
            beat <= '0;
            st   <= S_POP;
          end else if (sp_wr) begin
            sp <= sp_wdata;
          end
        end
        S_PUSH, S_POP: begin
          if (mem_rdy) begin
            if (st == S_POP) frame[beat] <= mem_rdata;
            if (beat == 3'(NW-1)) begin
              tcnt <= '0;
              st   <= (st == S_PUSH) ? S_PTAIL : S_QTAIL;
            end else begin
              beat <= beat + 3'd1;
            end
          end
        end
        S_PTAIL: begin
          if (tcnt == 8'(ETAIL-1)) begin
            handler_mode <= 1'b1;
            lr           <= RET_CODE;
            sp           <= base;
            st           <= S_IDLE;
          end else tcnt <= tcnt + 8'd1;
        end
        S_QTAIL: begin
          if (tcnt == 8'(XTAIL-1)) begin
            handler_mode <= 1'b0;
            sp           <= base + 32'd32 + (frame[NW-1][PAD_BIT] ? 32'd4 : 32'd0);
            ctx_restore  <= 1'b1;
            st           <= S_IDLE;
          end else tcnt <= tcnt + 8'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  lr_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(handler_mode) |-> lr == RET_CODE);

  // R2
  sp_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(handler_mode) |-> sp[2:0] == 3'b000);

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[PEND_BIT] && !tick_pend && !irq_req |=> tick_pend);

  // R6
  restore_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(handler_mode) |-> ctx_restore);
endmodule

// File: tb/test_exc_stacker.sv
module test_exc_stacker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sp_wr = 0, irq_req = 0, ctl_wr = 0, br_valid = 0;
  logic [31:0] sp_wdata = 0, ctl_wdata = 0, br_target = 0;
  logic [255:0] ctx_in = '0;
  logic [31:0] sp, lr, mem_addr, mem_wdata, mem_rdata;
  logic [255:0] ctx_out;
  logic tick_pend, handler_mode, busy, ctx_restore, mem_req, mem_we, mem_rdy;
  logic ws_en = 1'b0, waited = 1'b0;
  logic [31:0] mem [64];
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  exc_stacker i_exc_stacker (
    .clk(clk), .rst_n(rst_n), .sp_wr(sp_wr), .sp_wdata(sp_wdata), .sp(sp),
    .irq_req(irq_req), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .tick_pend(tick_pend),
    .ctx_in(ctx_in), .br_valid(br_valid), .br_target(br_target), .lr(lr),
    .handler_mode(handler_mode), .busy(busy), .ctx_out(ctx_out), .ctx_restore(ctx_restore),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy));

  assign mem_rdy   = ws_en ? waited : 1'b1;
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) begin
    if (mem_req && mem_we && mem_rdy) mem[mem_addr[7:2]] <= mem_wdata;
    waited <= mem_req && !mem_rdy;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_ctx(input int seed);
    logic [255:0] v;
    for (int i = 0; i < 7; i++) v[32*i +: 32] = 32'hA000_0000 + 32'(seed * 16 + i);
    v[255:224] = 32'h0100_0000 + 32'(seed);
    return v;
  endfunction

  task automatic set_sp(input logic [31:0] v);
    @(negedge clk); sp_wr = 1; sp_wdata = v;
    @(negedge clk); sp_wr = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 200) begin n++; @(negedge clk); end
  endtask

  task automatic t_entry(input logic [31:0] sp0, input int seed, input bit use_tick, input int exp_cyc);
    logic [31:0] exp_base, w;
    logic [255:0] c;
    int n;
    c = mk_ctx(seed);
    exp_base = sp0 - 32 - (sp0[2] ? 32'd4 : 32'd0);
    set_sp(sp0);
    @(negedge clk); ctx_in = c;
    if (use_tick) begin
      ctl_wr = 1; ctl_wdata = 32'h0400_0000;
      @(negedge clk);
      chk("R7", "pending after set", 32'(tick_pend), 1);
      chk("R7", "not yet busy", 32'(busy), 0);
      @(negedge clk); ctl_wr = 0; ctl_wdata = 0;
      chk("R8", "pending cleared on accept, repeat set lost", 32'(tick_pend), 0);
    end else begin
      irq_req = 1;
      @(negedge clk); irq_req = 0;
    end
    ctx_in = '0;
    count_busy(n);
    chk("R3", "entry cycles", 32'(n), 32'(exp_cyc));
    chk("R4", "handler mode", 32'(handler_mode), 1);
    chk("R4", "lr", lr, 32'hFFFF_FFF9);
    chk("R2", "sp after entry", sp, exp_base);
    for (int i = 0; i < 8; i++) begin
      w = c[32*i +: 32];
      if (i == 7) w[9] = sp0[2];
      chk("R1", $sformatf("frame word %0d", i), mem[exp_base[7:2] + 6'(i)], w);
    end
  endtask

  task automatic t_return(input logic [31:0] sp0, input int seed, input int exp_cyc);
    int n;
    @(negedge clk); br_valid = 1; br_target = 32'hFFFF_FFF9;
    @(negedge clk); br_valid = 0; br_target = 0;
    count_busy(n);
    chk("R3", "return cycles", 32'(n), 32'(exp_cyc));
    chk("R6", "thread mode", 32'(handler_mode), 0);
    chk("R6", "sp restored", sp, sp0);
    chk("R6", "restore strobe", 32'(ctx_restore), 1);
    for (int i = 0; i < 8; i++) begin
      logic [255:0] c;
      c = mk_ctx(seed);
      chk("R6", $sformatf("ctx word %0d", i), ctx_out[32*i +: 32], c[32*i +: 32]);
    end
    @(negedge clk);
    chk("R6", "strobe one cycle", 32'(ctx_restore), 0);
  endtask

  task automatic t_bad_branch(input logic [31:0] tgt, input logic exp_mode);
    logic [31:0] sp_before;
    sp_before = sp;
    @(negedge clk); br_valid = 1; br_target = tgt;
    @(negedge clk); br_valid = 0; br_target = 0;
    chk("R5", "no sequence started", 32'(busy), 0);
    @(negedge clk);
    chk("R5", "mode kept", 32'(handler_mode), 32'(exp_mode));
    chk("R5", "sp kept", sp, sp_before);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10", "handler", 32'(handler_mode), 0);
    chk("R10", "busy", 32'(busy), 0);
    chk("R10", "mem_req", 32'(mem_req), 0);
    chk("R10", "tick_pend", 32'(tick_pend), 0);
    chk("R10", "ctx_restore", 32'(ctx_restore), 0);
    chk("R10", "sp", sp, 0);
    chk("R10", "lr", lr, 0);
  endtask

  task automatic t_pend_clear_bit();
    @(negedge clk); ctl_wr = 1; ctl_wdata = 32'hFBFF_FFFF;
    @(negedge clk); ctl_wr = 0; ctl_wdata = 0;
    chk("R7", "bit 26 clear ignored", 32'(tick_pend), 0);
    @(negedge clk);
    chk("R7", "no entry", 32'(busy), 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pend_clear_bit();
    t_entry(32'h0000_00C0, 1, 1'b0, 12);
    t_bad_branch(32'hFFFF_FFF8, 1'b1);
    t_return(32'h0000_00C0, 1, 12);
    t_bad_branch(32'hFFFF_FFF9, 1'b0);
    t_entry(32'h0000_00C4, 2, 1'b1, 12);
    t_return(32'h0000_00C4, 2, 12);
    ws_en = 1'b1;
    t_entry(32'h0000_00BC, 3, 1'b0, 20);
    t_return(32'h0000_00BC, 3, 20);
    ws_en = 1'b0;
    set_sp(32'h0000_0080);
    @(negedge clk);
    chk("R10", "sp load while idle", sp, 32'h0000_0080);
    finish_run();
  end
endmodule